// File: doc/BRIEF.md
# Endpoint Buffer Packet Length Framer

This block sits between a 16-bit host bus and the packet buffers of one endpoint pair. It works in both directions. On the transmit side, the host writes whole words into a buffer. Word 0 holds the packet length. When the host starts a send, the block turns the payload words into a byte stream and sends exactly as many bytes as the length says. The final byte is marked as the end of the packet. If the length is odd, the upper byte of the last word is never sent.

On the receive side, incoming bytes are packed into words for the host. The received byte count is placed in header word 0 only once the packet ends. Until then, the host sees the length of the previous packet. When the count is odd, the block clears the upper byte of the final word, so stale buffer contents never show through.

Both buffers hold `DEPTH_W` words, and word 0 is the header. The payload therefore holds at most `CAP = 2*(DEPTH_W-1)` bytes. In either direction, a length larger than `CAP` is clamped to `CAP`, and that direction's overflow flag is raised.

Top module: `pkt_len_framer`

## Requirements
- R1: Transmit header word 0 carries the packet length in bytes as a 16-bit value. Bits 7:0 are the low byte and come first; bits 15:8 are the high byte.
- R2: After a start pulse while idle, the transmitter sends payload byte i from word 1+i/2. It takes bits 7:0 when i is even and bits 15:8 when i is odd. Bytes go out in index order, exactly the header count of them, and `tx_last` is high only on the final byte.
- R3: When the transmit length is odd, the upper byte of the last payload word is never presented on `tx_data`.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R5: A start with a header length of 0 sends no byte, and the transmitter stays idle.
- R6: A transmit header greater than CAP sends exactly CAP bytes, and `tx_ovf` reads 1. A header of CAP or less leaves `tx_ovf` at 0.
- R7: Received byte j is stored so that reading word 1+j/2 returns it in bits 7:0 when j is even and in bits 15:8 when j is odd.
- R8: Reading word 0 of the receive buffer returns the byte count of the last completed packet, zero-extended. The value changes only on the cycle a byte with `rx_last` is accepted.
- R9: Any byte position at or beyond the received count, including the upper byte of the last word of an odd-length packet, reads as 0.
- R10: A received packet longer than CAP keeps its first CAP bytes, drops the rest, records CAP as its length and sets `rx_ovf`. A packet of CAP bytes or fewer clears `rx_ovf`.
- R11: `out_rdata` presents the word addressed by `out_addr` in the cycle after `out_rd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_we | input | 1 | Write strobe for the transmit buffer |
| in_addr | input | AW | Word address of the transmit buffer write |
| in_wdata | input | 16 | Word written to the transmit buffer |
| in_go | input | 1 | Starts transmission of the buffered packet |
| in_busy | output | 1 | Transmission in progress |
| tx_valid | output | 1 | A byte is offered on tx_data |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | Byte consumer accepts the offered byte |
| tx_ovf | output | 1 | Last transmit header exceeded CAP |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Received byte ends the packet |
| rx_ovf | output | 1 | Last received packet exceeded CAP |
| out_rd | input | 1 | Read strobe for the receive buffer |
| out_addr | input | AW | Word address of the receive buffer read |
| out_rdata | output | 16 | Word read from the receive buffer |

## Verification
Transmit is tried with even, odd, zero and over-capacity lengths. The odd case writes a marker into the spare upper byte, so a framer that sends whole words is caught. The zero case catches a counter that wraps instead of staying idle. A run with a pseudo-random ready pattern separates correct holding of an offered byte from skipped or repeated bytes.

Receive is tried with even and odd lengths. The header is read in the middle of a packet to show that it is updated late. A packet that is too long is followed by a short one. This exposes stale upper bytes that were not masked, and an overflow flag that never clears.

// File: rtl/pkt_len_framer.sv
module pkt_len_framer #(
  parameter int DEPTH_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_we,
  input  logic [$clog2(DEPTH_W)-1:0] in_addr,
  input  logic [15:0]                in_wdata,
  input  logic                       in_go,
  output logic                       in_busy,
  output logic                       tx_valid,
  output logic [7:0]                 tx_data,
  output logic                       tx_last,
  input  logic                       tx_ready,
  output logic                       tx_ovf,
  input  logic                       rx_valid,
  input  logic [7:0]                 rx_data,
  input  logic                       rx_last,
  output logic                       rx_ovf,
  input  logic                       out_rd,
  input  logic [$clog2(DEPTH_W)-1:0] out_addr,
  output logic [15:0]                out_rdata
);
  localparam int AW  = $clog2(DEPTH_W);
  localparam int CAP = 2 * (DEPTH_W - 1);
  localparam int BW  = $clog2(CAP + 1);

  // transmit side
  logic [15:0]   in_mem [DEPTH_W];
  logic [BW-1:0] tx_len, tx_idx;
  logic [15:0]   tx_word;
  logic          hdr_big;

  always_ff @(posedge clk)
    if (in_we) in_mem[in_addr] <= in_wdata;

  assign hdr_big = in_mem[0] > 16'(CAP);
  assign tx_word = in_mem[AW'(tx_idx >> 1) + AW'(1)];
  assign tx_valid = in_busy;
  assign tx_data  = tx_idx[0] ? tx_word[15:8] : tx_word[7:0];
  assign tx_last  = in_busy && ((tx_idx + BW'(1)) == tx_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_busy <= 1'b0;
      tx_idx  <= '0;
      tx_len  <= '0;
      tx_ovf  <= 1'b0;
    end else if (in_go && !in_busy) begin
      tx_ovf  <= hdr_big;
      tx_len  <= hdr_big ? BW'(CAP) : in_mem[0][BW-1:0];
      tx_idx  <= '0;
      in_busy <= hdr_big || (in_mem[0] != 16'd0);
    end else if (in_busy && tx_ready) begin
      if (tx_last) in_busy <= 1'b0;
      else         tx_idx  <= tx_idx + BW'(1);
    end
  end

  // receive side
  logic [7:0]    rx_mem [CAP];
  logic [BW-1:0] rx_cnt, rx_hdr, lo_i, hi_i;
  logic          rx_over, rx_full;
  logic [7:0]    lo_b, hi_b;

  assign rx_full = rx_cnt == BW'(CAP);

  always_ff @(posedge clk)
    if (rx_valid && !rx_full) rx_mem[rx_cnt] <= rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt  <= '0;
      rx_over <= 1'b0;
      rx_hdr  <= '0;
      rx_ovf  <= 1'b0;
    end else if (rx_valid) begin
      if (rx_last) begin
        rx_hdr  <= rx_full ? BW'(CAP) : rx_cnt + BW'(1);
        rx_ovf  <= rx_over || rx_full;
        rx_cnt  <= '0;
        rx_over <= 1'b0;
      end else if (rx_full) begin
        rx_over <= 1'b1;
      end else begin
        rx_cnt <= rx_cnt + BW'(1);
      end
    end
  end

  assign lo_i = BW'({out_addr - AW'(1), 1'b0});
  assign hi_i = lo_i | BW'(1);
  assign lo_b = (lo_i < rx_hdr) ? rx_mem[lo_i] : 8'h00;
  assign hi_b = (hi_i < rx_hdr) ? rx_mem[hi_i] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n)      out_rdata <= '0;
    else if (out_rd) out_rdata <= (out_addr == '0) ? 16'(rx_hdr) : {hi_b, lo_b};
  end
endmodule

// File: rtl/pkt_len_framer_chk.sv
module pkt_len_framer_chk #(
  parameter int CAP = 62,
  parameter int BW  = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          rx_valid,
  input logic          rx_last,
  input logic [BW-1:0] rx_hdr
);
  logic [BW:0] sent;

  always_ff @(posedge clk) begin
    if (!rst_n) sent <= '0;
    else if (tx_valid && tx_ready) sent <= tx_last ? '0 : sent + 1'b1;
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  assert_last_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  assert_tx_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |-> sent < (BW+1)'(CAP));

  assert_hdr_late_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_last) |=> $stable(rx_hdr));

  assert_rx_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hdr <= BW'(CAP));
endmodule

bind pkt_len_framer pkt_len_framer_chk #(.CAP(CAP), .BW(BW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .rx_valid(rx_valid),
  .rx_last(rx_last), .rx_hdr(rx_hdr)
);

// File: tb/pkt_len_framer_tb_top.sv
module pkt_len_framer_tb_top;
  localparam int DEPTH_W = 32;
  localparam int AW  = $clog2(DEPTH_W);
  localparam int CAP = 2 * (DEPTH_W - 1);

  logic clk = 0, rst_n = 0;
  logic in_we = 0, in_go = 0, tx_ready = 1, rx_valid = 0, rx_last = 0, out_rd = 0;
  logic [AW-1:0] in_addr = '0, out_addr = '0;
  logic [15:0] in_wdata = '0;
  logic [7:0] rx_data = '0;
  logic in_busy, tx_valid, tx_last, tx_ovf, rx_ovf;
  logic [7:0] tx_data;
  logic [15:0] out_rdata;

  int checks = 0, errors = 0;
  string cur_req = "R2";
  logic [8:0] exp_q[$];
  logic [7:0] rx_model [128];
  logic rdy_mode = 0;
  logic [7:0] lfsr = 8'h5A;
  logic held_v = 0;
  logic [8:0] held;

  always #5 clk = ~clk;

  pkt_len_framer #(.DEPTH_W(DEPTH_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_we(in_we), .in_addr(in_addr), .in_wdata(in_wdata),
    .in_go(in_go), .in_busy(in_busy), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready), .tx_ovf(tx_ovf), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_last(rx_last), .rx_ovf(rx_ovf), .out_rd(out_rd),
    .out_addr(out_addr), .out_rdata(out_rdata)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int k, int seed);
    return 8'(k * 7 + seed);
  endfunction

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready = rdy_mode ? lfsr[0] : 1'b1;
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (held_v && tx_valid) chk("R4", {23'd0, tx_last, tx_data}, {23'd0, held});
      held_v = tx_valid && !tx_ready;
      held = {tx_last, tx_data};
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) chk({cur_req, " extra byte"}, {23'd0, tx_last, tx_data}, 32'h1FFFF);
        else chk(cur_req, {23'd0, tx_last, tx_data}, {23'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic wr_word(int a, logic [15:0] d);
    @(posedge clk); #1;
    in_we = 1; in_addr = AW'(a); in_wdata = d;
    @(posedge clk); #1;
    in_we = 0;
  endtask

  task automatic send_in(int len, int seed, string req);
    int n = (len > CAP) ? CAP : len;
    int nw = (n + 1) / 2;
    int w;
    cur_req = req;
    wr_word(0, 16'(len));  // R1: length in word 0, low byte in bits 7:0
    for (int k = 0; k < nw; k++) begin
      logic [7:0] hi = (2*k+1 < n) ? pat(2*k+1, seed) : 8'hEE;
      wr_word(k + 1, {hi, pat(2*k, seed)});
    end
    for (int i = 0; i < n; i++) exp_q.push_back({(i == n-1) ? 1'b1 : 1'b0, pat(i, seed)});
    @(posedge clk); #1; in_go = 1;
    @(posedge clk); #1; in_go = 0;
    w = 0;
    while ((in_busy || exp_q.size() != 0) && w < 4000) begin @(posedge clk); w++; end
    repeat (4) @(posedge clk);
    #2;
    chk({req, " queue drained"}, exp_q.size(), 0);
    chk({req, " idle"}, {31'd0, tx_valid}, 0);
    chk("R6 tx_ovf", {31'd0, tx_ovf}, (len > CAP) ? 1 : 0);
    exp_q.delete();
  endtask

  task automatic rx_send(int n, int seed, bit fin);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rx_valid = 1; rx_data = pat(i, seed); rx_last = fin && (i == n-1);
      rx_model[i] = pat(i, seed);
    end
    @(posedge clk); #1;
    rx_valid = 0; rx_last = 0;
  endtask

  task automatic rd_word(int a, output logic [15:0] d);
    @(posedge clk); #1;
    out_rd = 1; out_addr = AW'(a);
    @(posedge clk); #1;
    out_rd = 0;
    d = out_rdata;  // R11: one cycle after the strobe
  endtask

  task automatic check_out(int len, int words);
    logic [15:0] d;
    rd_word(0, d);
    chk("R8 header", d, len);
    for (int k = 0; k < words; k++) begin
      logic [7:0] lo = (2*k < len) ? rx_model[2*k] : 8'h00;
      logic [7:0] hi = (2*k+1 < len) ? rx_model[2*k+1] : 8'h00;
      rd_word(k + 1, d);
      chk((2*k+1 >= len) ? "R9 masked word" : "R7 packed word", d, {hi, lo});
    end
  endtask

  initial begin : watchdog
    #2_000_000;
    errors++;
    $display("FAIL WATCHDOG timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #3;
    chk("R5 reset tx_valid", {31'd0, tx_valid}, 0);
    chk("R6 reset tx_ovf", {31'd0, tx_ovf}, 0);
    chk("R10 reset rx_ovf", {31'd0, rx_ovf}, 0);
    rd_word(0, d);
    chk("R8 reset header", d, 0);

    send_in(6, 3, "R2");
    send_in(5, 40, "R3");
    rdy_mode = 1;
    send_in(23, 90, "R4");
    rdy_mode = 0;
    send_in(0, 1, "R5");
    chk("R5 not busy", {31'd0, in_busy}, 0);
    send_in(100, 11, "R6");
    send_in(258, 17, "R1");
    send_in(7, 2, "R6");

    rx_send(4, 20, 1);
    check_out(4, 3);
    rx_send(5, 60, 1);
    check_out(5, 4);
    chk("R10 no ovf", {31'd0, rx_ovf}, 0);
    rx_send(3, 99, 0);
    rd_word(0, d);
    chk("R8 mid-packet header", d, 5);
    @(posedge clk); #1;
    rx_valid = 1; rx_data = pat(3, 99); rx_last = 1; rx_model[3] = pat(3, 99);
    @(posedge clk); #1;
    rx_valid = 0; rx_last = 0;
    check_out(4, 2);
    rx_send(70, 5, 1);
    chk("R10 rx_ovf set", {31'd0, rx_ovf}, 1);
    check_out(CAP, CAP / 2);
    rx_send(3, 77, 1);
    chk("R10 rx_ovf cleared", {31'd0, rx_ovf}, 0);
    check_out(3, 4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule